// File: doc/BRIEF.md
# Half-Duplex Synchronous Serial Port

This block moves one byte at a time over a two-wire synchronous link made of a serial clock pin and a single data pin. The data pin serves both directions. Software picks the direction, the clock source and the idle behaviour through a small register port. It then loads a byte, starts a transfer and either polls a completion flag or waits for an interrupt request. As clock master the block derives the serial clock from the system clock through a programmable divider. As clock slave it follows an external clock, which it brings into the system clock domain through a synchronizer chain.

Each pin has a separate output-enable signal, so the pad ring can build tri-state or open-drain drivers. With handshaking enabled, the clock line rests high on an external pull-up. In that mode the block only ever pulls the clock line low and never drives it high. With handshaking disabled, the clock line rests low and is actively driven. Bits travel most significant first. Transmit data changes after a falling clock edge and receive data is captured on a rising edge.

Top module: `sync_serial_port`

Register map (`reg_addr`):

| Address | Register | Contents |
|---|---|---|
| 0 | CTRL | bit0 master, bit1 transmitter, bit2 handshake, bit3 interrupt enable; upper bits reserved |
| 1 | DATA | write loads the transmit byte; read returns the last received byte |
| 2 | STAT | read: bit0 busy, bit1 done; write with bit0 = 1 starts a transfer |
| 3 | DIV | half bit period of the master clock, in system clocks |

## Requirements
- R1: `sclk_oe` follows the clock role:
  - CTRL bit0 = 0 (slave): the block never enables its clock driver.
  - CTRL bit0 = 1 without handshake: the block enables the clock driver on every cycle.
- R2: `sdata_oe` is high exactly while CTRL bit1 (transmitter) is set. Otherwise the data pin is only an input.
- R3: A transfer contains exactly 16 clock edges, which make 8 pulses. When no transfer is running, a master produces no clock edge.
- R4: The idle clock level depends on CTRL bit2:
  - Handshake off: the idle clock line is low, actively driven.
  - Handshake on: the idle clock line is released (`sclk_oe` = 0) so that it rests high. The block never drives the line high in this mode.
- R5: The byte is sent or received most significant bit first. Transmit data shifts after each falling edge that follows a rising edge, and is valid at every rising edge. Receive data is sampled on rising edges and read back from DATA.
- R6: In master mode each clock half period lasts DIV system clocks. A DIV write below 2 stores 2, so a bit never takes fewer than 4 system clocks.
- R7: In slave mode, edges on `sclk_in` are synchronized into the system clock and drive the same transfer sequence. This applies to both transmit and receive and to both idle levels.
- R8: STAT bit1 (done) sets when the last edge of a transfer has been handled and busy (bit0) falls. A read or write of DATA clears it.
- R9: `irq` is high exactly when done is set and CTRL bit3 is set.
- R10: Reset and write protection of CTRL and DIV:
  - After reset, CTRL reads 0 and DIV reads 4.
  - CTRL bits 7..4 read 0 and ignore writes.
  - Writes to CTRL and DIV while busy are ignored.
- R11: A start write while a transfer is running is ignored. No extra clock edges follow the current transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| sclk_in | input | 1 | Clock pin level seen from the pad |
| sclk_out | output | 1 | Clock pin drive value |
| sclk_oe | output | 1 | Clock pin drive enable |
| sdata_in | input | 1 | Data pin level seen from the pad |
| sdata_out | output | 1 | Data pin drive value |
| sdata_oe | output | 1 | Data pin drive enable |
| irq | output | 1 | Transfer-complete interrupt request |

## Verification
The bench builds the block with its default sizes: an 8-bit byte, an 8-bit divider field and a two-stage synchronizer. Master transfers run with DIV values of 2, 3, 4 and 5. The smallest legal half period therefore exercises the closest spacing between the shift after a falling edge and the next sample. Slave transfers use an external clock much slower than the system clock, so every synchronized edge is seen and the pipeline latency is absorbed. With a one-byte frame, all 16 edges of each transfer and the clamp of DIV values 0 and 1 fall within the checks.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef struct packed {
    logic ien;
    logic hshk;
    logic tx;
    logic master;
  } ssp_ctrl_t;

  localparam int CTRL_BITS = 4;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

endpackage

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DIV_W     = 8,
  parameter int MIN_HALF  = 2,
  parameter int DIV_RESET = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              busy,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] rx_byte,
  output ssp_ctrl_t         ctrl,
  output logic [DATA_W-1:0] tx_byte,
  output logic [DIV_W-1:0]  half_div,
  output logic              start,
  output logic              irq
);

  localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_HALF);

  ssp_ctrl_t         ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] tx_q;
  logic              done_q;
  logic              data_touch;
  logic [CTRL_BITS-1:0] ctrl_bits;

  assign start      = wr && (addr == ADDR_STAT) && wdata[0] && !busy;
  assign data_touch = (wr || rd) && (addr == ADDR_DATA);
  assign ctrl_bits  = ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      div_q  <= DIV_W'(DIV_RESET);
      tx_q   <= '0;
      done_q <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr && !busy && addr == ADDR_CTRL)
        ctrl_q <= ssp_ctrl_t'(wdata[CTRL_BITS-1:0]);
      if (wr && !busy && addr == ADDR_DIV)
        div_q <= (wdata[DIV_W-1:0] < FLOOR) ? FLOOR : wdata[DIV_W-1:0];
      if (wr && addr == ADDR_DATA)
        tx_q <= wdata;
      if (xfer_done)
        done_q <= 1'b1;
      else if (data_touch)
        done_q <= 1'b0;
      if (rd) begin
        case (addr)
          ADDR_CTRL: rdata <= DATA_W'(ctrl_bits);
          ADDR_DATA: rdata <= rx_byte;
          ADDR_STAT: rdata <= DATA_W'({done_q, busy});
          default:   rdata <= DATA_W'(div_q);
        endcase
      end
    end
  end

  assign ctrl     = ctrl_q;
  assign half_div = div_q;
  assign tx_byte  = tx_q;
  assign irq      = done_q & ctrl_q.ien;

  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (rst)
    div_q >= FLOOR); // R6
  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |-> $stable(ctrl_q)); // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> !busy); // R8

endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             busy,
  input  logic             idle_lvl,
  input  logic [DIV_W-1:0] half_div,
  output logic             lvl
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lvl <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      lvl <= idle_lvl;
    end else if (busy) begin
      if (cnt == half_div - 1'b1) begin
        cnt <= '0;
        lvl <= ~lvl;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
      lvl <= idle_lvl;
    end
  end

  AST_LVL_STILL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) && !$past(busy, 2) && ($past(idle_lvl) == $past(idle_lvl, 2))
      |-> $stable(lvl)); // R3

endmodule

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              is_tx,
  input  logic              line,
  input  logic              din,
  output logic              busy,
  output logic              sdo,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);

  localparam int EDGES = 2 * DATA_W;
  localparam int CNT_W = $clog2(EDGES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES - 1);

  logic              line_q;
  logic              rise, fall;
  logic              seen_rise;
  logic [CNT_W-1:0]  ecnt;
  logic [DATA_W-1:0] sr, sr_nx;

  assign rise = line & ~line_q;
  assign fall = ~line & line_q;

  always_comb begin
    sr_nx = sr;
    if (busy && rise && !is_tx)
      sr_nx = {sr[DATA_W-2:0], din};
    else if (busy && fall && seen_rise && is_tx)
      sr_nx = {sr[DATA_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q    <= 1'b0;
      busy      <= 1'b0;
      seen_rise <= 1'b0;
      ecnt      <= '0;
      sr        <= '0;
      done      <= 1'b0;
      rx_byte   <= '0;
    end else begin
      line_q <= line;
      done   <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        sr        <= tx_byte;
        ecnt      <= '0;
        seen_rise <= 1'b0;
      end else if (busy && (rise || fall)) begin
        sr   <= sr_nx;
        ecnt <= ecnt + 1'b1;
        if (rise) seen_rise <= 1'b1;
        if (ecnt == LAST) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= sr_nx;
        end
      end
    end
  end

  assign sdo = sr[DATA_W-1];

  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (rst)
    busy |-> ecnt < CNT_W'(EDGES)); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy)); // R8

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_RESET   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              sdata_oe,
  output logic              irq
);

  localparam int MIN_HALF = 2;

  ssp_ctrl_t         ctrl;
  logic [DATA_W-1:0] tx_byte, rx_byte;
  logic [DIV_W-1:0]  half_div;
  logic              start, busy, done;
  logic              lvl, sclk_sync, line, sdo;

  ssp_regs #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .MIN_HALF(MIN_HALF), .DIV_RESET(DIV_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .xfer_done(done),
    .rx_byte(rx_byte), .ctrl(ctrl), .tx_byte(tx_byte), .half_div(half_div),
    .start(start), .irq(irq)
  );

  ssp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst(rst), .start(start), .busy(busy && ctrl.master),
    .idle_lvl(ctrl.hshk), .half_div(half_div), .lvl(lvl)
  );

  ssp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(sclk_in), .dout(sclk_sync)
  );

  assign line = ctrl.master ? lvl : sclk_sync;

  ssp_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .tx_byte(tx_byte), .is_tx(ctrl.tx),
    .line(line), .din(sdata_in), .busy(busy), .sdo(sdo), .done(done),
    .rx_byte(rx_byte)
  );

  // Handshake: low phases pulled down, high phases left to the pull-up.
  assign sclk_oe   = ctrl.master & (ctrl.hshk ? ~lvl : 1'b1);
  assign sclk_out  = ctrl.master & ~ctrl.hshk & lvl;
  assign sdata_oe  = ctrl.tx;
  assign sdata_out = sdo;

  AST_HS_NO_HIGH_DRIVE: assert property (@(posedge clk) disable iff (rst)
    ctrl.hshk |-> !(sclk_oe && sclk_out)); // R4
  AST_IDLE_PIN_LEVEL: assert property (@(posedge clk) disable iff (rst)
    ctrl.master && !busy && !$past(busy) && !$past(busy, 2) && $stable(ctrl) && ($past(ctrl) == $past(ctrl, 2))
      |-> (ctrl.hshk ? !sclk_oe : (sclk_oe && !sclk_out))); // R4

endmodule

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       sclk_in, sclk_out, sclk_oe, sdata_out, sdata_oe, irq;
  logic       sdata_in = 1'b0;
  logic       slave_clk = 1'b0;

  bit m_master, m_tx, m_hs, m_ien;
  int age;
  int checks = 0, errors = 0;
  bit finished = 0;

  assign sclk_in = m_master ? (sclk_oe ? sclk_out : m_hs) : slave_clk;

  sync_serial_port u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .irq(irq)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference monitor state
  bit mon_on = 0, active = 0, rise_seen, line_prev, ln, edg;
  int ecnt, since, half, bit_idx;
  logic [7:0] samp, pat;

  always @(negedge clk) begin
    if (mon_on) begin
      ln  = sclk_in;
      edg = (ln != line_prev);
      age++;
      chk(sdata_oe == m_tx, "R2", "data oe", sdata_oe, m_tx);
      if (m_master && !m_hs) chk(sclk_oe == 1'b1, "R1", "master clk oe", sclk_oe, 1);
      else if (m_master)     chk(!(sclk_oe && sclk_out), "R4", "hs drive high", sclk_out, 0);
      else                   chk(sclk_oe == 1'b0, "R1", "slave clk oe", sclk_oe, 0);
      if (active) begin
        if (edg) begin
          ecnt++;
          if (m_master) chk(since == half, "R6", "half period", since, half);
          since = 1;
          if (ln) begin
            samp = {samp[6:0], sdata_out};
            rise_seen = 1;
          end else if (rise_seen) begin
            bit_idx++;
            if (bit_idx < 8) sdata_in = pat[7-bit_idx];
          end
          if (ecnt == 16) active = 0;
        end else begin
          since++;
        end
      end else if (m_master && age > 2) begin
        chk(!edg, "R3", "stray clock edge", edg, 0);
        chk(ln == m_hs, "R4", "idle clock level", ln, m_hs);
      end
      line_prev = ln;
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_ctrl(bit master, bit tx, bit hs, bit ien);
    wr(2'd0, {4'b0, ien, hs, tx, master});
    m_master = master; m_tx = tx; m_hs = hs; m_ien = ien; age = 0;
  endtask

  task automatic setup(bit master, bit tx, bit hs, bit ien, int h, logic [7:0] b);
    slave_clk = hs;
    set_ctrl(master, tx, hs, ien);
    if (master) wr(2'd3, 8'(h));
    wr(2'd1, b);
    pat = b; sdata_in = b[7]; samp = '0; bit_idx = 0; rise_seen = 0;
    ecnt = 0; half = h;
    repeat (4) @(posedge clk);
  endtask

  task automatic start_xfer();
    @(posedge clk); #1;
    reg_addr = 2'd2; reg_wdata = 8'h01; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    since = 0; active = 1;
  endtask

  task automatic drive_or_wait(bit master);
    if (!master) begin
      repeat (4) @(posedge clk);
      for (int i = 0; i < 16; i++) begin
        repeat (10) @(posedge clk);
        #1 slave_clk = ~slave_clk;
      end
    end else begin
      for (int i = 0; i < 3000 && active; i++) @(posedge clk);
    end
    repeat (8) @(posedge clk);
  endtask

  task automatic finish(bit tx, bit ien, logic [7:0] b, string req, bit clear);
    logic [7:0] d;
    chk(ecnt == 16, "R3", "edges per transfer", ecnt, 16);
    active = 0;
    rd(2'd2, d);
    chk(d == 8'h02, "R8", "status after transfer", d, 2);
    chk(irq == ien, "R9", "irq after transfer", irq, ien);
    if (tx) chk(samp == b, req, "bits seen on data pin", samp, b);
    if (clear) begin
      if (tx) wr(2'd1, 8'h00);
      else begin
        rd(2'd1, d);
        chk(d == b, req, "received byte", d, b);
      end
      rd(2'd2, d);
      chk(d == 8'h00, "R8", "done cleared by data access", d, 0);
      chk(irq == 1'b0, "R9", "irq after clear", irq, 0);
    end
  endtask

  task automatic xfer(bit master, bit tx, bit hs, bit ien, int h, logic [7:0] b, string req);
    setup(master, tx, hs, ien, h, b);
    start_xfer();
    drive_or_wait(master);
    finish(tx, ien, b, req, 1);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) @(posedge clk);
    line_prev = sclk_in;
    mon_on = 1;
    // R10 reset state
    rd(2'd0, d); chk(d == 8'h00, "R10", "ctrl after reset", d, 0);
    rd(2'd3, d); chk(d == 8'h04, "R10", "div after reset", d, 4);
    rd(2'd2, d); chk(d == 8'h00, "R8", "status after reset", d, 0);
    chk(irq == 1'b0, "R9", "irq after reset", irq, 0);
    chk(sclk_oe == 1'b0, "R1", "clk oe after reset", sclk_oe, 0);

    // R5 master transfers, both idle levels
    xfer(1, 1, 0, 1, 2, 8'hA5, "R5");
    xfer(1, 1, 1, 1, 3, 8'h3C, "R5");
    xfer(1, 0, 0, 1, 5, 8'hC9, "R5");
    xfer(1, 0, 1, 1, 2, 8'h81, "R5");
    // R7 slave transfers
    xfer(0, 1, 0, 1, 10, 8'h5A, "R7");
    xfer(0, 0, 1, 1, 10, 8'hE7, "R7");
    xfer(0, 0, 0, 0, 10, 8'h18, "R7");
    xfer(0, 1, 1, 1, 10, 8'hB1, "R7");

    // R11 and R10: writes during a running transfer
    setup(1, 1, 0, 1, 4, 8'h66);
    start_xfer();
    repeat (5) @(posedge clk);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'hFF);
    wr(2'd3, 8'h09);
    drive_or_wait(1);
    chk(ecnt == 16, "R11", "restart ignored", ecnt, 16);
    finish(1, 1, 8'h66, "R5", 1);
    rd(2'd0, d); chk(d == 8'h0B, "R10", "ctrl write while busy ignored", d, 8'h0B);
    rd(2'd3, d); chk(d == 8'h04, "R10", "div write while busy ignored", d, 4);

    // R9 mask gating with a pending done
    setup(1, 1, 0, 0, 2, 8'h0F);
    start_xfer();
    drive_or_wait(1);
    finish(1, 0, 8'h0F, "R5", 0);
    set_ctrl(1, 1, 0, 1);
    @(negedge clk);
    chk(irq == 1'b1, "R9", "irq on enable with done", irq, 1);
    wr(2'd1, 8'h00);
    @(negedge clk);
    chk(irq == 1'b0, "R8", "data write clears done", irq, 0);

    // R10 reserved bits
    wr(2'd0, 8'hF5);
    m_master = 1; m_tx = 0; m_hs = 1; m_ien = 0; age = 0;
    rd(2'd0, d); chk(d == 8'h05, "R10", "reserved ctrl bits", d, 5);

    // R6 divider floor
    wr(2'd3, 8'h00); rd(2'd3, d); chk(d == 8'h02, "R6", "div clamp 0", d, 2);
    wr(2'd3, 8'h01); rd(2'd3, d); chk(d == 8'h02, "R6", "div clamp 1", d, 2);
    wr(2'd3, 8'h07); rd(2'd3, d); chk(d == 8'h07, "R6", "div plain", d, 7);

    repeat (10) @(posedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule